// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small binary counter that moves in either direction under two separate strobe inputs instead of a direction bit. A rising edge on the up strobe adds one to the count, provided the down strobe is idle high at that moment. A rising edge on the down strobe subtracts one, provided the up strobe is idle high. Both strobes are asynchronous to the system clock. They pass through a synchroniser, and their rising edges are detected inside the system clock domain.

Clear (active high) and parallel load (active low) act on levels. Their effect on the output appears in the same clock cycle: a combinational mux in front of the stored count shows zero or the load data at once, and the register takes that value at the next system clock edge. The active-low carry and borrow outputs mark terminal count while the matching strobe is low. A chain of these blocks can therefore feed one stage's carry or borrow into the next stage's strobe.

Top module: `updn_strobe_counter`

## Requirements
- R1: After a synchronous reset, q is 0 and both co_n and bo_n are 1.
- R2: A rising up_stb while dn_stb is high increments q by one, and 15 wraps to 0.
- R3: A rising dn_stb while up_stb is high decrements q by one, and 0 wraps to 15.
- R4: A rising up_stb while dn_stb is held low leaves q unchanged. A rising dn_stb while up_stb is low also leaves q unchanged.
- R5: When both strobes rise so that their synchronised edges fall in the same clock cycle, q is unchanged.
- R6: While clr is 1, q reads 0 in that same cycle, and q stays 0 after clr is released.
- R7: While load_n is 0, q equals d in that same cycle, and q keeps that value after load_n returns to 1.
- R8: When clr and load_n are both asserted, clear wins and q reads 0.
- R9: co_n is 0 exactly when q is 15 and the synchronised up strobe is low, and 1 otherwise.
- R10: bo_n is 0 exactly when q is 0 and the synchronised down strobe is low, and 1 otherwise.
- R11: A strobe rising edge changes q at the third rising clock edge after it. q is unchanged after the second edge.
- R12: Asserting load with d = 13 whenever a down count reaches 2 makes the counter cycle 13 down to 3. The value 2 is shown only until the load takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_stb | input | 1 | Count-up strobe, asynchronous, idle high |
| dn_stb | input | 1 | Count-down strobe, asynchronous, idle high |
| clr | input | 1 | Level clear, active high |
| load_n | input | 1 | Level parallel load, active low |
| d | input | WIDTH | Parallel load value |
| q | output | WIDTH | Count |
| co_n | output | 1 | Carry, active low, at 15 while up strobe is low |
| bo_n | output | 1 | Borrow, active low, at 0 while down strobe is low |

## Verification
Clear and load appear on q in the cycle they are applied, so the bench samples one time step after driving them. A strobe edge reaches q on the third rising clock edge after it. The bench changes strobes just after a falling edge, checks the old value after two edges, and samples at the falling edge after the third. Carry and borrow follow the synchronised strobe level two edges late, so they are checked after the strobe has been low for three cycles.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Qualified edges: each direction needs the opposite strobe idle high.
  function automatic step_e decode_step(input logic up_rise, input logic up_lvl,
                                        input logic dn_rise, input logic dn_lvl);
    logic go_up;
    logic go_dn;
    go_up = up_rise & dn_lvl;
    go_dn = dn_rise & up_lvl;
    if (go_up && !go_dn)      return STEP_UP;
    else if (go_dn && !go_up) return STEP_DOWN;
    else                      return STEP_HOLD;
  endfunction

endpackage

// File: rtl/updn_strobe_edge.sv
module updn_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic lvl,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], stb};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R11: a detected edge lasts exactly one clock
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  input  logic             up_rise,
  input  logic             up_lvl,
  input  logic             dn_rise,
  input  logic             dn_lvl,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  step_e step;
  assign step = decode_step(up_rise, up_lvl, dn_rise, dn_lvl);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!load_n) cnt <= d;
    else begin
      case (step)
        STEP_UP:   cnt <= cnt + ONE;
        STEP_DOWN: cnt <= cnt - ONE;
        default:   cnt <= cnt;
      endcase
    end
  end

  // R2 R3 R4: without clear or load the stored count moves by at most one
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE ||
                          cnt == $past(cnt) - ONE));

  // R4: an up edge without the down strobe high never increments
  gated_up_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !clr && up_rise && !dn_lvl && !dn_rise) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/updn_flags.sv
module updn_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             co_n,
  output logic             bo_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  assign co_n = !((q == TOP) && !up_lvl);
  assign bo_n = !((q == '0) && !dn_lvl);

endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             co_n,
  output logic             bo_n
);
  logic up_lvl, up_rise, dn_lvl, dn_rise;
  logic [WIDTH-1:0] cnt;

  updn_strobe_edge #(.STAGES(SYNC_STAGES)) u_up (
    .clk(clk), .rst(rst), .stb(up_stb), .lvl(up_lvl), .rise(up_rise));

  updn_strobe_edge #(.STAGES(SYNC_STAGES)) u_dn (
    .clk(clk), .rst(rst), .stb(dn_stb), .lvl(dn_lvl), .rise(dn_rise));

  updn_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .d(d),
    .up_rise(up_rise), .up_lvl(up_lvl), .dn_rise(dn_rise), .dn_lvl(dn_lvl),
    .cnt(cnt));

  // Immediate view: clear beats load, load beats the stored count.
  always_comb begin
    if (clr)          q = '0;
    else if (!load_n) q = d;
    else              q = cnt;
  end

  updn_flags #(.WIDTH(WIDTH)) u_flags (
    .q(q), .up_lvl(up_lvl), .dn_lvl(dn_lvl), .co_n(co_n), .bo_n(bo_n));

  // R6: a clear leaves zero behind once it has been taken
  clear_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!load_n || clr || q == '0));

  // R7: a load leaves its data behind once released
  load_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !clr) |=> (!load_n || clr || q == $past(d) ||
                           q == $past(d) + WIDTH'(1) || q == $past(d) - WIDTH'(1)));

endmodule

// File: tb/updn_strobe_counter_test.sv
module updn_strobe_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_stb = 1'b1, dn_stb = 1'b1, clr = 1'b0, load_n = 1'b1;
  logic [3:0] d = 4'd0;
  logic [3:0] q;
  logic co_n, bo_n;
  int checks = 0, errors = 0;
  logic [3:0] model = 4'd0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_strobe_counter uut (
    .clk(clk), .rst(rst), .up_stb(up_stb), .dn_stb(dn_stb), .clr(clr),
    .load_n(load_n), .d(d), .q(q), .co_n(co_n), .bo_n(bo_n));

  function automatic logic [3:0] exp_up(input logic [3:0] v);
    return v + 4'd1;
  endfunction
  function automatic logic [3:0] exp_dn(input logic [3:0] v);
    return v - 4'd1;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_up(input bit see_flag);
    up_stb = 1'b0;
    edges(4);
    if (see_flag) chk("R9 co_n", {3'b0, co_n}, {3'b0, !(model == 4'd15)});
    up_stb = 1'b1;
    edges(4);
    model = exp_up(model);
    chk("R2 up count", q, model);
  endtask

  task automatic pulse_dn(input bit see_flag);
    dn_stb = 1'b0;
    edges(4);
    if (see_flag) chk("R10 bo_n", {3'b0, bo_n}, {3'b0, !(model == 4'd0)});
    dn_stb = 1'b1;
    edges(4);
    model = exp_dn(model);
    chk("R3 down count", q, model);
  endtask

  task automatic do_load(input logic [3:0] v);
    d = v; load_n = 1'b0;
    #1 chk("R7 load immediate", q, v);
    edges(1);
    load_n = 1'b1;
    model = v;
    #1 chk("R7 load held", q, v);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    #1 chk("R6 clear immediate", q, 4'd0);
    edges(2);
    clr = 1'b0;
    model = 4'd0;
    #1 chk("R6 clear held", q, 4'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    edges(3);
    rst = 1'b0;
    edges(1);
    // R1
    chk("R1 reset q", q, 4'd0);
    chk("R1 reset co_n", {3'b0, co_n}, 4'd1);
    chk("R1 reset bo_n", {3'b0, bo_n}, 4'd1);

    // R11 latency: change lands on third edge
    up_stb = 1'b0; edges(4);
    up_stb = 1'b1;
    edges(2);
    chk("R11 not yet after two edges", q, 4'd0);
    edges(1);
    chk("R11 after third edge", q, 4'd1);
    model = 4'd1;

    // R2 wrap 13,14,15,0,1,2 with carry
    do_load(4'd13);
    for (int i = 0; i < 5; i++) pulse_up(1'b1);
    chk("R2 wrap end", q, 4'd2);

    // R3 wrap 2,1,0,15,14,13 with borrow
    for (int i = 0; i < 5; i++) pulse_dn(1'b1);
    chk("R3 wrap end", q, 4'd13);

    // R4: up edge with down held low is ignored; release of down then counts down
    dn_stb = 1'b0; edges(4);
    up_stb = 1'b0; edges(4);
    up_stb = 1'b1; edges(4);
    chk("R4 gated up ignored", q, model);
    dn_stb = 1'b1; edges(4);
    model = exp_dn(model);
    chk("R3 down after gated up", q, model);

    // R5: simultaneous rising edges cancel
    up_stb = 1'b0; dn_stb = 1'b0; edges(4);
    up_stb = 1'b1; dn_stb = 1'b1; edges(4);
    chk("R5 both edges hold", q, model);

    // R8: clear beats load
    d = 4'd9; load_n = 1'b0; clr = 1'b1;
    #1 chk("R8 clear over load", q, 4'd0);
    edges(1);
    load_n = 1'b1; clr = 1'b0; model = 4'd0;
    #1 chk("R8 after release", q, 4'd0);

    // R10 borrow sits high while down strobe idle
    chk("R10 bo_n idle", {3'b0, bo_n}, 4'd1);

    // R12: down counter 13..3 by reloading at 2
    do_load(4'd5);
    for (int i = 0; i < 14; i++) begin
      pulse_dn(1'b0);
      if (model == 4'd2) begin
        chk("R12 reaches two", q, 4'd2);
        do_load(4'd13);
        chk("R12 reloaded", q, 4'd13);
      end
    end

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      case ($urandom % 6)
        0, 1: pulse_up(1'b1);
        2, 3: pulse_dn(1'b1);
        4:    do_load(4'($urandom % 16));
        default: do_clear();
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule